// File: doc/BRIEF.md
# Dual-Cache Coherence Controller

This block keeps two small direct-mapped private caches coherent over one shared, word-addressed memory. Each of two processor ports issues single-word reads and writes. The block holds a tag, a data word, a valid flag and a dirty flag for every line of each cache. All coherence work passes through one shared bus that carries a single transaction at a time, and a round-robin arbiter picks which port gets it.

A `policy` input picks how writes are made coherent. With policy 0 (invalidate), a write takes ownership: the writer's line becomes dirty, any copy in the peer cache is killed, and memory is left stale. Later writes to an owned line stay local. A peer that then reads the address stalls while the owner writes the word back and clears its dirty flag. With policy 1 (update), every write goes straight to memory and to every cached copy. Those copies carry a dirty flag only while the write is in flight.

The controller is one state machine. The states are IDLE (arbitrate and decide), EVICT (write back a dirty victim), PEER_WB (write back the peer's dirty copy), FILL_RD (issue a memory read), FILL_WR (install the returned word), WRITE (apply the write under the latched policy), UPD_CLR (clear the dirty flags after an update) and DONE (one-cycle ready pulse). The transitions are as follows.
- IDLE→DONE on a read hit.
- IDLE→EVICT on a miss or a write whose line holds another dirty address.
- IDLE→PEER_WB on a read miss that the peer holds dirty.
- IDLE→FILL_RD on a clean read miss.
- IDLE→WRITE on a write with no dirty victim.
- EVICT→WRITE for a write.
- EVICT→PEER_WB or EVICT→FILL_RD for a read.
- PEER_WB→FILL_RD→FILL_WR→DONE.
- WRITE→DONE under invalidate.
- WRITE→UPD_CLR→DONE under update.
- DONE→IDLE.

Top module: `dual_coh_ctrl`

## Requirements
- R1: A read miss fetches the word from memory, installs it clean in the requester's cache and returns it, with ready seen 3 clock edges after the request is taken. A read hit returns the cached word after 1 edge.
- R2: With policy 0, a write leaves the writer's line valid and dirty and invalidates any copy in the peer cache. It does not write memory, and it completes after 2 edges.
- R3: A write to a line that the writer already holds dirty completes locally after 2 edges. It causes no memory write and no change to the peer cache.
- R4: A read of an address that the peer holds dirty stalls. The peer's word is written to memory and the peer's dirty flag is cleared, then the requester is filled. This takes 4 edges, and the peer keeps a valid clean copy.
- R5: With policy 1, a write updates memory and every cached copy of the address before ready. It completes after 3 edges, and a later read from either port returns the new word.
- R6: With policy 1, every copy of the written address is marked dirty during the write cycle. All those dirty flags are cleared in the next cycle, so evicting those copies later costs no write-back.
- R7: Only one access is served at a time. Port 0 wins the first simultaneous request after reset. After that, a tie goes to the port that was not granted last.
- R8: Each port's ready stays low until its access completes and then is high for exactly one cycle. The port holds req, we, addr and wdata steady until it sees ready.
- R9: The line index is the low log2(LINES) address bits. If the line in the requester's cache holds a different, dirty address, that word is written back to memory before the new address is installed, and this adds 1 edge.
- R10: Reset clears every valid and dirty flag, keeps ready and mem_we low, and returns port 0 to first priority. The policy input is sampled only when an access is granted from IDLE, so a change during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 1 | 0 = invalidate on write, 1 = update on write |
| req | input | 2 | Access request, one bit per port |
| we | input | 2 | Write enable, one bit per port |
| addr | input | 2×AW | Word address per port |
| wdata | input | 2×DW | Write data per port |
| ready | output | 2 | One-cycle completion pulse per port |
| rdata | output | DW | Read data, valid with ready |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after mem_addr |

## Verification
Short directed sequences on one line index check the controller through latency and data. A hit, a clean miss, a miss that needs a peer write-back and an eviction each take a different number of cycles, so the bench can tell apart a copy that was invalidated from one that was kept stale. A switch of the policy input during an access shows whether the policy is sampled only at grant. Simultaneous requests right after reset and after a one-sided grant check which port the arbiter serves first. A full address sweep under each policy writes from one port and reads from the other. A pseudo-random mix of ports, operations, addresses and policy switches is then checked against a bench memory image to expose stale data left by conflict evictions.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_EVICT,
        S_PEER_WB,
        S_FILL_RD,
        S_FILL_WR,
        S_WRITE,
        S_UPD_CLR,
        S_DONE
    } coh_state_e;

    localparam logic POL_INVALIDATE = 1'b0;
    localparam logic POL_UPDATE     = 1'b1;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       adv,
    output logic       gnt_idx,
    output logic       gnt_vld
);
    logic last_q;

    // last_q starts at 1 so that port 0 wins the first tie
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   last_q <= 1'b1;
        else if (adv) last_q <= gnt_idx;
    end

    always_comb begin
        gnt_vld = |req;
        if (req == 2'b11) gnt_idx = ~last_q;
        else              gnt_idx = req[1];
    end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store #(
    parameter int LINES = 4,
    parameter int TW    = 4,
    parameter int DW    = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_valid,
    output logic          rd_dirty,
    output logic [TW-1:0] rd_tag,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_valid,
    input  logic          wr_dirty,
    input  logic [TW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data
);
    logic [LINES-1:0] val_q;
    logic [LINES-1:0] dty_q;
    logic [TW-1:0]    tag_q [LINES];
    logic [DW-1:0]    dat_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            dty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (wr_en) begin
            val_q[wr_idx] <= wr_valid;
            dty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = val_q[rd_idx];
    assign rd_dirty = dty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (val_q == '0 && dty_q == '0)); // R10
    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dty_q & ~val_q) == '0); // R2
endmodule

// File: rtl/dual_coh_ctrl.sv
module dual_coh_ctrl
    import coh_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int LINES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                policy,
    input  logic [1:0]          req,
    input  logic [1:0]          we,
    input  logic [1:0][AW-1:0]  addr,
    input  logic [1:0][DW-1:0]  wdata,
    output logic [1:0]          ready,
    output logic [DW-1:0]       rdata,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    coh_state_e    state_q, state_d;
    logic          cur_q;
    logic          pol_q;
    logic [DW-1:0] rdata_q;

    logic gnt_idx, gnt_vld, adv;

    // per-cache lookup and write buses
    logic [1:0]    lv, ld;
    logic [TW-1:0] lt [2];
    logic [DW-1:0] lq [2];
    logic [1:0]    cw_en, cw_v, cw_d;
    logic [TW-1:0] cw_t [2];
    logic [DW-1:0] cw_q [2];

    logic          sel, oth;
    logic [AW-1:0] a_sel;
    logic [IW-1:0] idx;
    logic [TW-1:0] tag;
    logic          own_hit, peer_hit, victim_dirty, peer_dirty, upd_mode;

    coh_rr_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .adv    (adv),
        .gnt_idx(gnt_idx),
        .gnt_vld(gnt_vld)
    );

    for (genvar c = 0; c < 2; c++) begin : g_cache
        coh_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (idx),
            .rd_valid(lv[c]),
            .rd_dirty(ld[c]),
            .rd_tag  (lt[c]),
            .rd_data (lq[c]),
            .wr_en   (cw_en[c]),
            .wr_idx  (idx),
            .wr_valid(cw_v[c]),
            .wr_dirty(cw_d[c]),
            .wr_tag  (cw_t[c]),
            .wr_data (cw_q[c])
        );
    end

    assign adv          = (state_q == S_IDLE) && gnt_vld;
    assign sel          = (state_q == S_IDLE) ? gnt_idx : cur_q;
    assign oth          = ~sel;
    assign a_sel        = addr[sel];
    assign idx          = a_sel[IW-1:0];
    assign tag          = a_sel[AW-1:IW];
    assign own_hit      = lv[sel] && (lt[sel] == tag);
    assign peer_hit     = lv[oth] && (lt[oth] == tag);
    assign victim_dirty = lv[sel] && ld[sel] && !own_hit;
    assign peer_dirty   = peer_hit && ld[oth];
    assign upd_mode     = (pol_q == POL_UPDATE);

    // state register and per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= 1'b0;
            pol_q   <= POL_INVALIDATE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (adv) begin
                cur_q <= gnt_idx;
                pol_q <= policy;
                if (!we[gnt_idx] && own_hit) rdata_q <= lq[sel];
            end
            if (state_q == S_FILL_WR) rdata_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (gnt_vld) begin
                    if (we[sel])           state_d = victim_dirty ? S_EVICT : S_WRITE;
                    else if (own_hit)      state_d = S_DONE;
                    else if (victim_dirty) state_d = S_EVICT;
                    else if (peer_dirty)   state_d = S_PEER_WB;
                    else                   state_d = S_FILL_RD;
                end
            end
            S_EVICT: begin
                if (we[sel])         state_d = S_WRITE;
                else if (peer_dirty) state_d = S_PEER_WB;
                else                 state_d = S_FILL_RD;
            end
            S_PEER_WB: state_d = S_FILL_RD;
            S_FILL_RD: state_d = S_FILL_WR;
            S_FILL_WR: state_d = S_DONE;
            S_WRITE:   state_d = upd_mode ? S_UPD_CLR : S_DONE;
            S_UPD_CLR: state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs and array writes
    always_comb begin
        ready     = '0;
        mem_we    = 1'b0;
        mem_addr  = a_sel;
        mem_wdata = wdata[sel];
        for (int c = 0; c < 2; c++) begin
            cw_en[c] = 1'b0;
            cw_v[c]  = lv[c];
            cw_d[c]  = ld[c];
            cw_t[c]  = lt[c];
            cw_q[c]  = lq[c];
        end
        unique case (state_q)
            S_IDLE, S_FILL_RD: ;
            S_EVICT: begin
                mem_we    = 1'b1;
                mem_addr  = {lt[sel], idx};
                mem_wdata = lq[sel];
                cw_en[sel] = 1'b1;
                cw_v[sel]  = 1'b0;
                cw_d[sel]  = 1'b0;
            end
            S_PEER_WB: begin
                mem_we    = 1'b1;
                mem_wdata = lq[oth];
                cw_en[oth] = 1'b1;
                cw_d[oth]  = 1'b0;
            end
            S_FILL_WR: begin
                cw_en[sel] = 1'b1;
                cw_v[sel]  = 1'b1;
                cw_d[sel]  = 1'b0;
                cw_t[sel]  = tag;
                cw_q[sel]  = mem_rdata;
            end
            S_WRITE: begin
                cw_en[sel] = 1'b1;
                cw_v[sel]  = 1'b1;
                cw_d[sel]  = 1'b1;
                cw_t[sel]  = tag;
                cw_q[sel]  = wdata[sel];
                if (upd_mode) begin
                    mem_we = 1'b1;
                    if (peer_hit) begin
                        cw_en[oth] = 1'b1;
                        cw_d[oth]  = 1'b1;
                        cw_q[oth]  = wdata[sel];
                    end
                end else if (peer_hit) begin
                    cw_en[oth] = 1'b1;
                    cw_v[oth]  = 1'b0;
                    cw_d[oth]  = 1'b0;
                end
            end
            S_UPD_CLR: begin
                cw_en[sel] = 1'b1;
                cw_d[sel]  = 1'b0;
                if (peer_hit) begin
                    cw_en[oth] = 1'b1;
                    cw_d[oth]  = 1'b0;
                end
            end
            S_DONE: ready[cur_q] = 1'b1;
            default: ;
        endcase
    end

    assign rdata = rdata_q;

    AST_INV_KILLS_PEER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && !upd_mode) |=> !peer_hit); // R2
    AST_INV_OWNER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && !upd_mode) |=> (own_hit && ld[sel])); // R2
    AST_LOCAL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && !upd_mode) |-> !mem_we); // R3
    AST_PEER_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PEER_WB) |=> (peer_hit && !peer_dirty)); // R4
    AST_UPD_ALL_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && upd_mode) |=> (own_hit && ld[sel] && (!peer_hit || ld[oth]))); // R6
    AST_UPD_ALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UPD_CLR) |=> (own_hit && !ld[sel] && !peer_dirty)); // R6
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready) |=> !(|ready)); // R8
    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ready)); // R7
    AST_EVICT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVICT) |=> !victim_dirty); // R9
endmodule

// File: tb/sim_dual_coh_ctrl.sv
module sim_dual_coh_ctrl;
    localparam int AW = 6, DW = 8, LINES = 4, NW = 64;

    logic                clk = 1'b0, rst_n = 1'b0, policy = 1'b0;
    logic [1:0]          req = '0, we = '0;
    logic [1:0][AW-1:0]  addr = '0;
    logic [1:0][DW-1:0]  wdata = '0;
    logic [1:0]          ready;
    logic [DW-1:0]       rdata;
    logic                mem_we;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_wdata, mem_rdata;

    logic [DW-1:0] mem [NW];
    int            gold [NW];
    int            n_chk = 0, n_fail = 0, wb_cnt = 0;

    always #2 clk = ~clk;

    dual_coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
        .clk(clk), .rst_n(rst_n), .policy(policy), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wb_cnt        <= wb_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic int init_val(int a);
        return (a * 5 + 3) & 255;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic access(int p, bit w, int a, int d, output int rd, output int lat);
        req[p]   = 1'b1;
        we[p]    = w;
        addr[p]  = a[AW-1:0];
        wdata[p] = d[DW-1:0];
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (ready[p] !== 1'b1);
        rd = int'(rdata);
        req[p] = 1'b0;
        if (w) gold[a] = d;
    endtask

    task automatic op(int p, bit w, int a, int d, output int rd, output int lat);
        @(negedge clk);
        access(p, w, a, d, rd, lat);
    endtask

    task automatic op_chk(int p, bit w, int a, int d, string tag);
        int rd, lat, exp;
        exp = gold[a];
        op(p, w, a, d, rd, lat);
        if (!w) chk(tag, rd, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8: watchdog expired, got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int rd, lat, rd0, rd1, lat0, lat1, m, d;
        logic [15:0] lfsr;
        for (int i = 0; i < NW; i++) begin
            mem[i]  = init_val(i);
            gold[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", int'(ready), 0);
        chk("R10 mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;

        // R7: first tie after reset goes to port 0 (both miss on address 3)
        @(negedge clk);
        fork
            access(0, 1'b0, 3, 0, rd0, lat0);
            access(1, 1'b0, 3, 0, rd1, lat1);
        join
        chk("R7 tie port0 latency", lat0, 3);
        chk("R7 tie port1 latency", lat1, 7);
        chk("R1 tie read data", rd1, init_val(3));

        // invalidate policy
        op(0, 1'b0, 5, 0, rd, lat);
        chk("R1 miss latency", lat, 3);
        chk("R1 miss data", rd, init_val(5));
        @(negedge clk);
        chk("R8 ready single pulse", int'(ready), 0);
        op(0, 1'b0, 5, 0, rd, lat);
        chk("R1 hit latency", lat, 1);
        chk("R1 hit data", rd, init_val(5));
        op(1, 1'b0, 5, 0, rd, lat);
        chk("R1 peer clean miss latency", lat, 3);
        m = wb_cnt;
        op(1, 1'b1, 5, 8'hA5, rd, lat);
        chk("R2 invalidate write latency", lat, 2);
        chk("R2 no memory write", wb_cnt, m);
        chk("R2 memory stale", int'(mem[5]), init_val(5));
        op(1, 1'b1, 5, 8'h5A, rd, lat);
        chk("R3 owned write latency", lat, 2);
        chk("R3 owned write no memory traffic", wb_cnt, m);
        op(0, 1'b0, 5, 0, rd, lat);
        chk("R4 stalled read latency", lat, 4);
        chk("R4 stalled read data", rd, 8'h5A);
        chk("R4 written back", int'(mem[5]), 8'h5A);
        op(1, 1'b0, 5, 0, rd, lat);
        chk("R4 peer keeps copy latency", lat, 1);
        chk("R4 peer keeps copy data", rd, 8'h5A);
        m = wb_cnt;
        op(1, 1'b0, 9, 0, rd, lat);
        chk("R4 peer dirty cleared, clean evict latency", lat, 3);
        chk("R4 peer dirty cleared, no write-back", wb_cnt, m);
        op(0, 1'b1, 13, 8'h33, rd, lat);
        chk("R2 write miss latency", lat, 2);
        m = wb_cnt;
        op(0, 1'b1, 9, 8'h99, rd, lat);
        chk("R9 dirty eviction latency", lat, 3);
        chk("R9 victim written back", int'(mem[13]), 8'h33);
        chk("R9 one write-back", wb_cnt, m + 1);
        op(1, 1'b0, 9, 0, rd, lat);
        chk("R2 peer invalidated latency", lat, 4);
        chk("R2 peer invalidated data", rd, 8'h99);

        // R10: policy change during an access is ignored
        m = wb_cnt;
        fork
            op(0, 1'b1, 9, 8'h44, rd, lat);
            begin
                @(negedge clk);
                @(negedge clk);
                policy = 1'b1;
            end
        join
        chk("R10 policy latched latency", lat, 2);
        chk("R10 policy latched no memory write", wb_cnt, m);
        op(1, 1'b0, 9, 0, rd, lat);
        chk("R10 read after latched invalidate", rd, 8'h44);

        // update policy
        op(0, 1'b0, 20, 0, rd, lat);
        op(1, 1'b0, 20, 0, rd, lat);
        m = wb_cnt;
        op(0, 1'b1, 20, 8'h77, rd, lat);
        chk("R5 update write latency", lat, 3);
        chk("R5 memory updated", int'(mem[20]), 8'h77);
        chk("R5 single memory write", wb_cnt, m + 1);
        op(1, 1'b0, 20, 0, rd, lat);
        chk("R5 peer copy hit latency", lat, 1);
        chk("R5 peer copy data", rd, 8'h77);
        m = wb_cnt;
        op(1, 1'b0, 24, 0, rd, lat);
        chk("R6 peer copy clean evict latency", lat, 3);
        op(0, 1'b0, 24, 0, rd, lat);
        chk("R6 writer copy clean evict latency", lat, 3);
        chk("R6 no write-back after update", wb_cnt, m);

        // R7: after port 0 was granted last, a tie goes to port 1
        @(negedge clk);
        fork
            access(0, 1'b0, 24, 0, rd0, lat0);
            access(1, 1'b0, 24, 0, rd1, lat1);
        join
        chk("R7 alternate port1 latency", lat1, 1);
        chk("R7 alternate port0 latency", lat0, 3);

        // sweep every address under both policies
        for (int pol = 0; pol < 2; pol++) begin
            policy = pol[0];
            for (int a = 0; a < NW; a++) begin
                d = (a * 7 + pol * 64 + 1) & 255;
                op(a % 2, 1'b1, a, d, rd, lat);
                if (pol == 1) chk("R5 sweep memory", int'(mem[a]), d);
                op_chk(1 - a % 2, 1'b0, a, 0, "R4 sweep peer read");
                op_chk(a % 2, 1'b0, a, 0, "R1 sweep own read");
            end
        end

        // pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if ((i % 16) == 0) policy = lfsr[3];
            op_chk(int'(lfsr[0]), lfsr[1], int'(lfsr[7:2]), int'(lfsr[15:8]), "R1 random read");
            if (lfsr[1] && policy)
                chk("R5 random memory", int'(mem[lfsr[7:2]]), int'(lfsr[15:8]));
        end

        // R10: reset empties the caches
        op(0, 1'b0, 7, 0, rd, lat);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        op(0, 1'b0, 7, 0, rd, lat);
        chk("R10 miss after reset latency", lat, 3);
        chk("R10 miss after reset data", rd, gold[7]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule